// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block holds the eight-bit status register, the control register and the interrupt logic of a UART that sits on a microprocessor bus. It does not shift serial data. It receives event and level inputs from the receive and transmit datapaths: a character-transfer pulse with its parity and framing flags, the transmitter's holding-empty and shift-empty levels, and the clear-to-send line. It also takes two peripheral inputs. One is a level-sensitive external status line. The other is a peripheral status line that reacts to its falling edge.

A processor reaches the block through a chip select, a register-select line, a read/write line and a bus strobe. With register select high, a write loads the control register and a read returns status. With register select low, a read returns the received character and a write hands a character to the transmitter. Each interrupt source is cleared by its own bus action. Most sources clear on the leading edge of the strobe, and the peripheral status source clears on the trailing edge. A single registered active-low interrupt output reports every pending source that the control bits enable.

Top module: `uart_sic`

## Requirements
- R1: While `clr_n` is low at a clock edge, the control register, all status bits and all pending interrupt sources clear. After that edge `int_n` is 1, `ctrl_o` is 0 and a status read returns 0 as long as the transmitter levels are low and `es_n` is high.
- R2: While `cs`, `strobe` and `rd` are all high, `rdata` shows the status byte if `sel`=1 and `rx_data` if `sel`=0. At all other times `rdata` is 0. Status bit positions from bit 7 down to bit 0 are: transmit-holding-empty, transmit-shift-empty, peripheral-status, external-status, framing, parity, overrun, data-available.
- R3: A cycle with `rx_load`=1 sets data-available (bit 0) and copies `rx_pe` into bit 2 and `rx_fe` into bit 3. In the same cycle, bit 1 (overrun) takes the value that bit 0 held before the load.
- R4: A data read (`sel`=0, `rd`=1) clears data-available on the strobe's leading edge (the first clock with `strobe` high after a low). If a load happens in the same cycle, the load wins.
- R5: Status bit 4 is 1 one clock after `es_n` is sampled low and 0 one clock after `es_n` is sampled high.
- R6: A falling edge on `psi_n` sets status bit 5. A status read clears bit 5 on the strobe's trailing edge (the first clock with `strobe` low after a high). If a new falling edge arrives in that cycle, it wins.
- R7: A rising edge of `thre_in`, or a rising edge of `thre_in`&`tsre_in`, makes that source pending. Both sources clear on the leading edge of a status read or of a data write. A new rising edge in the clearing cycle wins.
- R8: A rising edge of `cts` while `thre_in` and `tsre_in` are both 1 makes a source pending, and a status read's leading edge clears it. A `cts` edge with either level low has no effect.
- R9: `int_n` is registered. It goes low one clock after the control IE bit (bit 0) is 1 and any of these is pending: data-available, peripheral-status, transmitter-done, clear-to-send, or holding-empty together with control TR bit (bit 1). Otherwise it is 1.
- R10: A control write (`sel`=1, `rd`=0) loads `wdata` into `ctrl_o` on the leading edge. A data write raises `tx_load` for exactly the leading-edge cycle. Accesses with `cs`=0 change nothing.
- R11: The pin outputs follow the status bits: `da_n` is the inverse of bit 0, `err_o` is bit 1 OR bit 2, `fe_o` is bit 3, and `thre_n` is the inverse of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous clear, active low |
| cs | input | 1 | Chip select |
| strobe | input | 1 | Bus strobe; leading and trailing edges are detected |
| sel | input | 1 | 1 selects control/status, 0 selects data |
| rd | input | 1 | 1 for a read, 0 for a write |
| wdata | input | DW | Write data from the bus |
| rdata | output | DW | Read data to the bus, 0 when not reading |
| rx_data | input | DW | Received character from the receive datapath |
| rx_load | input | 1 | One-cycle pulse: a character was moved to the holding register |
| rx_pe | input | 1 | Parity error of the transferred character |
| rx_fe | input | 1 | Framing error of the transferred character |
| thre_in | input | 1 | Transmit holding register empty level |
| tsre_in | input | 1 | Transmit shift register empty level |
| cts | input | 1 | Clear-to-send from the peripheral |
| es_n | input | 1 | External status, active low level |
| psi_n | input | 1 | Peripheral status interrupt, falling-edge sensitive |
| ctrl_o | output | DW | Control register contents |
| tx_load | output | 1 | One-cycle pulse: a character write to the transmitter |
| int_n | output | 1 | Interrupt request, active low, registered |
| da_n | output | 1 | Data available, active low |
| err_o | output | 1 | Parity or overrun error |
| fe_o | output | 1 | Framing error |
| thre_n | output | 1 | Holding register empty, active low |

## Verification
The hardest case to reach is a source that must clear on one strobe edge while a different source or a new event lands on the other edge. Examples are a peripheral-status bit that survives a status read until the strobe falls, and a character load that coincides with the data read meant to clear it. The stimulus stretches the strobe over several cycles and places `rx_load` and `psi_n` edges in the exact leading-edge cycle. A behavioural model advances every clock and checks the interrupt line and the read data in each of those cycles.

// File: rtl/uart_sic_pkg.sv
package uart_sic_pkg;
  localparam int ST_DA   = 0;
  localparam int ST_OE   = 1;
  localparam int ST_PE   = 2;
  localparam int ST_FE   = 3;
  localparam int ST_ES   = 4;
  localparam int ST_PSI  = 5;
  localparam int ST_TSRE = 6;
  localparam int ST_THRE = 7;
  localparam int STW     = 8;

  localparam int CT_IE = 0;
  localparam int CT_TR = 1;

  // {sel, rd}
  typedef enum logic [1:0] {
    ACC_DATA_WR = 2'b00,
    ACC_DATA_RD = 2'b01,
    ACC_CTRL_WR = 2'b10,
    ACC_STAT_RD = 2'b11
  } acc_e;

  typedef struct packed {
    logic ctrl_wr;
    logic stat_rd_lead;
    logic stat_rd_trail;
    logic data_rd_lead;
    logic data_wr_lead;
  } bus_ev_t;

  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic irq_want(input logic ie, input logic tr,
                                    input logic da, input logic psi,
                                    input logic thre_p, input logic done_p,
                                    input logic cts_p);
    return ie & (da | psi | done_p | cts_p | (tr & thre_p));
  endfunction
endpackage

// File: rtl/usic_bus_decode.sv
module usic_bus_decode
  import uart_sic_pkg::*;
(
  input  logic    clk,
  input  logic    clr_n,
  input  logic    cs,
  input  logic    strobe,
  input  logic    sel,
  input  logic    rd,
  output bus_ev_t ev,
  output logic    rd_window
);
  logic strobe_q;
  logic stat_rd_lat;
  logic lead, trail, hit;
  acc_e acc;

  assign acc   = acc_e'({sel, rd});
  assign lead  = rise(strobe, strobe_q);
  assign trail = rise(strobe_q, strobe);
  assign hit   = cs & lead;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      strobe_q    <= strobe;
      stat_rd_lat <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (lead) stat_rd_lat <= hit && (acc == ACC_STAT_RD);
    end
  end

  always_comb begin
    ev               = '0;
    ev.ctrl_wr       = hit && (acc == ACC_CTRL_WR);
    ev.stat_rd_lead  = hit && (acc == ACC_STAT_RD);
    ev.data_rd_lead  = hit && (acc == ACC_DATA_RD);
    ev.data_wr_lead  = hit && (acc == ACC_DATA_WR);
    ev.stat_rd_trail = trail & stat_rd_lat;
  end

  assign rd_window = cs & strobe & rd;
endmodule

// File: rtl/usic_status.sv
module usic_status
  import uart_sic_pkg::*;
(
  input  logic           clk,
  input  logic           clr_n,
  input  logic           rx_load,
  input  logic           rx_pe,
  input  logic           rx_fe,
  input  logic           thre_in,
  input  logic           tsre_in,
  input  logic           cts,
  input  logic           es_n,
  input  logic           psi_n,
  input  logic           da_clr,
  input  logic           psi_clr,
  output logic [STW-1:0] stat,
  output logic           thre_rise,
  output logic           done_rise,
  output logic           cts_evt
);
  logic psi_q, cts_q, psi_fall;

  assign psi_fall  = rise(psi_q, psi_n);
  assign thre_rise = rise(thre_in, stat[ST_THRE]);
  assign done_rise = rise(thre_in & tsre_in, stat[ST_THRE] & stat[ST_TSRE]);
  assign cts_evt   = rise(cts, cts_q) & thre_in & tsre_in;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      stat  <= '0;
      psi_q <= psi_n;
      cts_q <= cts;
    end else begin
      psi_q          <= psi_n;
      cts_q          <= cts;
      stat[ST_THRE]  <= thre_in;
      stat[ST_TSRE]  <= tsre_in;
      stat[ST_ES]    <= ~es_n;
      if (psi_fall)     stat[ST_PSI] <= 1'b1;
      else if (psi_clr) stat[ST_PSI] <= 1'b0;
      if (rx_load) begin
        stat[ST_DA] <= 1'b1;
        stat[ST_OE] <= stat[ST_DA];
        stat[ST_PE] <= rx_pe;
        stat[ST_FE] <= rx_fe;
      end else if (da_clr) begin
        stat[ST_DA] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usic_irq.sv
module usic_irq
  import uart_sic_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic ie,
  input  logic tr,
  input  logic da,
  input  logic psi,
  input  logic thre_rise,
  input  logic done_rise,
  input  logic cts_evt,
  input  logic tx_clr,
  input  logic cts_clr,
  output logic int_n
);
  logic thre_p, done_p, cts_p;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      thre_p <= 1'b0;
      done_p <= 1'b0;
      cts_p  <= 1'b0;
      int_n  <= 1'b1;
    end else begin
      if (thre_rise)   thre_p <= 1'b1;
      else if (tx_clr) thre_p <= 1'b0;
      if (done_rise)   done_p <= 1'b1;
      else if (tx_clr) done_p <= 1'b0;
      if (cts_evt)      cts_p <= 1'b1;
      else if (cts_clr) cts_p <= 1'b0;
      int_n <= ~irq_want(ie, tr, da, psi, thre_p, done_p, cts_p);
    end
  end
endmodule

// File: rtl/uart_sic.sv
module uart_sic
  import uart_sic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          cs,
  input  logic          strobe,
  input  logic          sel,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_load,
  input  logic          rx_pe,
  input  logic          rx_fe,
  input  logic          thre_in,
  input  logic          tsre_in,
  input  logic          cts,
  input  logic          es_n,
  input  logic          psi_n,
  output logic [DW-1:0] ctrl_o,
  output logic          tx_load,
  output logic          int_n,
  output logic          da_n,
  output logic          err_o,
  output logic          fe_o,
  output logic          thre_n
);
  bus_ev_t        ev;
  logic           rd_window;
  logic [STW-1:0] stat;
  logic           thre_rise, done_rise, cts_evt;
  logic           tx_clr;

  usic_bus_decode u_dec (
    .clk(clk), .clr_n(clr_n), .cs(cs), .strobe(strobe), .sel(sel), .rd(rd),
    .ev(ev), .rd_window(rd_window)
  );

  usic_status u_stat (
    .clk(clk), .clr_n(clr_n), .rx_load(rx_load), .rx_pe(rx_pe), .rx_fe(rx_fe),
    .thre_in(thre_in), .tsre_in(tsre_in), .cts(cts), .es_n(es_n), .psi_n(psi_n),
    .da_clr(ev.data_rd_lead), .psi_clr(ev.stat_rd_trail), .stat(stat),
    .thre_rise(thre_rise), .done_rise(done_rise), .cts_evt(cts_evt)
  );

  assign tx_clr = ev.stat_rd_lead | ev.data_wr_lead;

  usic_irq u_irq (
    .clk(clk), .clr_n(clr_n), .ie(ctrl_o[CT_IE]), .tr(ctrl_o[CT_TR]),
    .da(stat[ST_DA]), .psi(stat[ST_PSI]), .thre_rise(thre_rise),
    .done_rise(done_rise), .cts_evt(cts_evt), .tx_clr(tx_clr),
    .cts_clr(ev.stat_rd_lead), .int_n(int_n)
  );

  always_ff @(posedge clk) begin
    if (!clr_n)          ctrl_o <= '0;
    else if (ev.ctrl_wr) ctrl_o <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd_window) rdata = sel ? DW'(stat) : rx_data;
  end

  assign tx_load = ev.data_wr_lead;
  assign da_n    = ~stat[ST_DA];
  assign err_o   = stat[ST_OE] | stat[ST_PE];
  assign fe_o    = stat[ST_FE];
  assign thre_n  = ~stat[ST_THRE];
endmodule

// File: rtl/uart_sic_chk.sv
module uart_sic_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          clr_n,
  input logic          strobe,
  input logic          es_n,
  input logic          psi_n,
  input logic          rx_load,
  input logic          tx_load,
  input logic          int_n,
  input logic          da_n,
  input logic [7:0]    stat,
  input logic [DW-1:0] ctrl_o,
  input logic [DW-1:0] rdata
);
  AST_IE_GATES_INT: assert property (@(posedge clk) disable iff (!clr_n)
    !ctrl_o[0] |=> int_n); // R9
  AST_DA_ON_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    rx_load |=> !da_n); // R3
  AST_ES_SET: assert property (@(posedge clk) disable iff (!clr_n)
    !es_n |=> stat[4]); // R5
  AST_ES_DROP: assert property (@(posedge clk) disable iff (!clr_n)
    es_n |=> !stat[4]); // R5
  AST_PSI_LATCH: assert property (@(posedge clk) disable iff (!clr_n)
    $fell(psi_n) |=> stat[5]); // R6
  AST_TXLOAD_SINGLE: assert property (@(posedge clk) disable iff (!clr_n)
    tx_load |=> !tx_load); // R10
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!clr_n)
    !strobe |-> rdata == '0); // R2
endmodule

bind uart_sic uart_sic_chk #(.DW(DW)) u_chk (.*);

// File: tb/uart_sic_test.sv
module uart_sic_test;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic clr_n = 1'b0, cs = 1'b0, strobe = 1'b0, sel = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0, rx_data = '0;
  logic rx_load = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0;
  logic thre_in = 1'b0, tsre_in = 1'b0, cts = 1'b0, es_n = 1'b1, psi_n = 1'b1;
  logic [DW-1:0] rdata, ctrl_o;
  logic tx_load, int_n, da_n, err_o, fe_o, thre_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit started = 0;

  // reference model state
  bit [7:0] m_st = 0;
  bit [7:0] m_ctrl = 0;
  bit m_tp = 0, m_dp = 0, m_cp = 0, m_int = 1;
  bit m_sq = 0, m_psiq = 1, m_ctsq = 0, m_lat = 0;

  uart_sic #(.DW(DW)) uut (.*);

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    bit lead, trail, srd, drd, dwr, cwr, strl, n_int, thr_r, dn_r, cts_r, psi_f;
    bit [7:0] st;
    cyc++;
    started = 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (!clr_n) begin
      m_st = 0; m_ctrl = 0; m_tp = 0; m_dp = 0; m_cp = 0; m_int = 1;
      m_sq = strobe; m_psiq = psi_n; m_ctsq = cts; m_lat = 0;
    end else begin
      lead  = strobe && !m_sq;
      trail = !strobe && m_sq;
      srd = lead && cs && sel && rd;
      drd = lead && cs && !sel && rd;
      dwr = lead && cs && !sel && !rd;
      cwr = lead && cs && sel && !rd;
      strl = trail && m_lat;
      n_int = !(m_ctrl[0] && (m_st[0] || m_st[5] || m_dp || m_cp || (m_ctrl[1] && m_tp)));
      thr_r = thre_in && !m_st[7];
      dn_r  = thre_in && tsre_in && !(m_st[7] && m_st[6]);
      cts_r = cts && !m_ctsq && thre_in && tsre_in;
      psi_f = !psi_n && m_psiq;
      if (thr_r) m_tp = 1; else if (srd || dwr) m_tp = 0;
      if (dn_r) m_dp = 1; else if (srd || dwr) m_dp = 0;
      if (cts_r) m_cp = 1; else if (srd) m_cp = 0;
      st = m_st;
      st[7] = thre_in; st[6] = tsre_in; st[4] = !es_n;
      if (psi_f) st[5] = 1; else if (strl) st[5] = 0;
      if (rx_load) begin
        st[1] = m_st[0]; st[0] = 1; st[2] = rx_pe; st[3] = rx_fe;
      end else if (drd) st[0] = 0;
      m_st = st;
      if (cwr) m_ctrl = wdata;
      if (lead) m_lat = srd;
      m_sq = strobe; m_psiq = psi_n; m_ctsq = cts;
      m_int = n_int;
    end
  end

  always @(negedge clk) begin
    bit [7:0] e_rd;
    if (started) begin
      e_rd = (cs && strobe && rd) ? (sel ? m_st : rx_data) : 8'h00;
      check("R9 int_n", int_n, m_int);
      check("R2 rdata", rdata, e_rd);
      check("R10 ctrl_o", ctrl_o, m_ctrl);
      check("R10 tx_load", tx_load, cs && !sel && !rd && strobe && !m_sq && clr_n);
      check("R4 da_n", da_n, !m_st[0]);
      check("R3 err_o", err_o, m_st[1] || m_st[2]);
      check("R11 fe_o", fe_o, m_st[3]);
      check("R11 thre_n", thre_n, !m_st[7]);
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic bus(input bit c, input bit s, input bit r, input bit [7:0] wd, input int hold);
    tick(); cs = c; sel = s; rd = r; wdata = wd; strobe = 1;
    repeat (hold) tick();
    strobe = 0; tick(); cs = 0; sel = 0; rd = 0;
  endtask

  task automatic stat_read(output bit [7:0] v);
    tick(); cs = 1; sel = 1; rd = 1; strobe = 1;
    #5 v = rdata;
    tick(); tick(); strobe = 0; tick(); cs = 0; rd = 0; sel = 0;
    tick(); tick();
  endtask

  task automatic load(input bit pe, input bit fe, input bit [7:0] d);
    tick(); rx_data = d; rx_pe = pe; rx_fe = fe; rx_load = 1;
    tick(); rx_load = 0; rx_pe = 0; rx_fe = 0;
  endtask

  initial begin
    bit [7:0] v;
    repeat (3) tick();
    clr_n = 1; tick();
    check("R1 int_n after clear", int_n, 1);
    check("R1 ctrl after clear", ctrl_o, 0);
    stat_read(v); check("R1 status after clear", v, 0);

    bus(1, 1, 0, 8'h01, 1); tick();
    load(1, 0, 8'hA5); tick(); tick();
    check("R9 int on data", int_n, 0);
    stat_read(v); check("R3 status DA+PE", v, 8'h05);
    tick(); cs = 1; rd = 1; strobe = 1; #5 check("R2 data read", rdata, 8'hA5);
    tick(); strobe = 0; tick(); cs = 0; rd = 0; tick(); tick();
    check("R4 DA cleared", da_n, 1);
    check("R4 int released", int_n, 1);

    load(0, 0, 8'h11); load(0, 0, 8'h22); tick();
    stat_read(v); check("R3 overrun", v, 8'h03);
    bus(1, 0, 1, 0, 1); tick();

    es_n = 0; tick(); tick();
    stat_read(v); check("R5 ES set", v[4], 1);
    es_n = 1; tick(); tick();
    stat_read(v); check("R5 ES clear", v[4], 0);

    psi_n = 0; tick(); tick();
    check("R6 int on psi", int_n, 0);
    tick(); cs = 1; sel = 1; rd = 1; strobe = 1;
    tick(); tick(); tick();
    check("R6 held until trail", int_n, 0);
    strobe = 0; tick(); cs = 0; sel = 0; rd = 0; tick();
    check("R6 cleared at trail", int_n, 1);
    psi_n = 1; tick();

    thre_in = 1; tick(); tick(); tick();
    check("R9 TR gates THRE", int_n, 1);
    bus(1, 1, 0, 8'h03, 1); tick();
    check("R7 THRE int", int_n, 0);
    stat_read(v); check("R7 THRE bit", v[7], 1);
    check("R7 THRE cleared", int_n, 1);

    tsre_in = 1; tick(); tick(); tick();
    check("R7 done int", int_n, 0);
    bus(1, 0, 0, 8'h55, 1); tick();
    check("R7 cleared by write", int_n, 1);

    cts = 1; tick(); tick(); tick();
    check("R8 cts int", int_n, 0);
    stat_read(v);
    check("R8 cts cleared", int_n, 1);
    cts = 0; tsre_in = 0; tick(); cts = 1; tick(); tick(); tick();
    check("R8 cts ignored", int_n, 1);
    cts = 0; tick();

    bus(1, 1, 0, 8'h00, 1);
    psi_n = 0; tick(); tick(); tick();
    check("R9 IE off", int_n, 1);
    bus(1, 1, 0, 8'h01, 1); tick();
    check("R9 IE on", int_n, 0);
    psi_n = 1; stat_read(v);

    bus(0, 1, 0, 8'hFF, 1); tick();
    check("R10 no cs", ctrl_o, 8'h01);

    load(0, 0, 8'h33); tick();
    tick(); cs = 1; rd = 1; strobe = 1; rx_load = 1;
    tick(); rx_load = 0; strobe = 0; tick(); cs = 0; rd = 0; tick();
    check("R4 load wins", da_n, 0);

    load(0, 1, 8'h44); tick();
    check("R11 fe pin", fe_o, 1);
    check("R11 thre pin", thre_n, 0);

    clr_n = 0; tick(); clr_n = 1; tick();
    check("R1 mid clear int", int_n, 1);
    check("R1 mid clear ctrl", ctrl_o, 0);
    check("R1 mid clear da", da_n, 1);
    repeat (4) tick();
    finish_run();
  end
endmodule